// File: doc/BRIEF.md
# Single-Precision Reciprocal Square Root Estimator

This unit takes one binary32 operand and returns an estimate of 1/sqrt(x) with eight fraction bits of accuracy, plus an invalid-operation flag and a divide-by-zero flag. A caller pulses `start` with the operand and two mode bits. Special operands finish in a single cycle. Finite positive operands pass through a short pipeline of states. First, a subnormal operand is normalised one left shift per cycle. Next, a nine-bit scaled value is formed, and its form depends on whether the working exponent is odd or even. Last, a sequential integer search runs. It uses one multiply per cycle and stops when a product bound is crossed.

The search widens the scaled value `s` (range 128..511) into a core value `a`. If `s < 256`, then `a = 2s+1`. Otherwise the low bit of `s` is cleared and `a = 2*(s+1)`. The search counter `b` starts at 512 and increases by one per cycle while `a*(b+1)^2 < 2^28`. The estimate is `(b+1)/2`, which always lies in 256..511. The low eight bits of the estimate become the top of the result mantissa. The result exponent is `(380 - e)/2`, where `e` is the working exponent.

A result is presented with a one-cycle `done` pulse. The result and flags then hold until the next accepted operation. No new operation is accepted while `busy` is high.

Top module: `rsq_est`

## Requirements
- R1: A zero operand returns infinity with the operand's sign (0x7F800000 or 0xFF800000) and sets `flag_divzero`. `flag_invalid` stays clear.
- R2: A negative non-zero, non-NaN operand returns the default NaN 0x7FC00000 and sets `flag_invalid`. This covers negative normals, negative subnormals without flushing, and negative infinity.
- R3: Positive infinity (0x7F800000) returns +0 (0x00000000) with both flags clear.
- R4: A NaN is an operand with exponent field 255 and a non-zero fraction. Fraction bit 22 set marks a quiet NaN, and bit 22 clear marks a signalling NaN. A signalling NaN sets `flag_invalid` and is returned with bit 22 set, keeping its sign and payload. A quiet NaN is returned unchanged with no flag. When `dnan_en` is 1, every NaN returns 0x7FC00000; the invalid flag still follows the signalling rule.
- R5: When `ftz_en` is 1, a subnormal operand (exponent field 0, fraction non-zero) is treated as a zero of the same sign, so R1 applies. Normal operands are unaffected by `ftz_en`.
- R6: For a finite positive operand, the core value `a` lies in 257..1022. The search yields an estimate in 256..511. Result bit 31 is 0, bits 22:15 carry the estimate's low eight bits, and bits 14:0 are zero.
- R7: If the working exponent is odd, the scaled value is binary 01 followed by fraction bits 22:16. If it is even, the scaled value is 1 followed by fraction bits 22:15. For example, 1.0 gives 0x3F7F8000 and 2.0 gives 0x3F348000.
- R8: When `ftz_en` is 0, a subnormal operand is shifted left once per step until fraction bit 22 is 1, and each shift decrements the working exponent from 0. One further left shift then drops the leading one. For example, 0x00000001 gives 0x64B48000 and 0x00400000 gives 0x5F348000.
- R9: Result bits 30:23 hold `(380 - e)/2`. For example, 4.0 gives 0x3EFF8000 and 0x7F7FFFFF gives 0x1F800000.
- R10: For a special operand, `done` pulses in the cycle after `start` is sampled, with `busy` low. For a finite positive operand, `busy` rises in the cycle after `start` and stays high until `done`. `done` is high for exactly one cycle. After reset, `done`, `busy`, `result` and both flags are 0.
- R11: A `start` pulse while `busy` is high is ignored. The running operation completes with its own result.
- R12: The search performs at most `ITER_LIMIT` increments. With the default limit of 512, the longest operand (scaled value 128) finishes within 520 cycles of `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; sampled only when not busy |
| operand | input | 32 | binary32 operand, sampled with `start` |
| ftz_en | input | 1 | Treat subnormal operands as signed zero |
| dnan_en | input | 1 | Replace every NaN result with the default NaN |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse marking a new result |
| result | output | 32 | binary32 estimate, held until the next accepted operation |
| flag_invalid | output | 1 | Invalid-operation flag for the current result |
| flag_divzero | output | 1 | Divide-by-zero flag for the current result |

## Verification
The bench builds the unit with the default `ITER_LIMIT` of 512. This limit is large enough that no operand reaches the cap, so every core value can be compared against an independent software search. The sweep covers all 384 scaled values, using an odd exponent for 128..255 and an even exponent for 256..511. It also includes the slowest case, which needs 510 increments, so the iteration bound and the busy window are exercised at their worst. A vector table covers the special classes and the mode bits. Further vectors exercise subnormals at both shift extremes (0 and 22 shifts) and the exponent extremes.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Floating-point format and derived constants
    localparam int FP_W       = 32;
    localparam int EXP_W      = 8;
    localparam int MAN_W      = 23;
    localparam int EXP_BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int EXP_OFFSET = 3 * EXP_BIAS - 1;
    localparam int WEXP_W     = EXP_W + 2;

    // Core search geometry
    localparam int SCALE_W      = 9;
    localparam int CORE_W       = SCALE_W + 1;
    localparam int B_W          = SCALE_W + 2;
    localparam int SEARCH_START = 1 << SCALE_W;
    localparam int BOUND_LOG2   = 28;
    localparam int PROD_W       = 32;
    localparam int EST_OUT_W    = 8;
    localparam int PAD_W        = MAN_W - EST_OUT_W;

    localparam logic [FP_W-1:0] DEFAULT_NAN = 32'h7FC0_0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_NORM,
        ST_LAUNCH,
        ST_WAIT
    } ctl_state_t;

    typedef struct packed {
        logic            special;
        logic [FP_W-1:0] value;
        logic            invalid;
        logic            divzero;
    } special_t;

    // Widen a scaled value (128..511) into the core search operand
    function automatic logic [CORE_W-1:0] widen_core(input logic [SCALE_W-1:0] s);
        if (s[SCALE_W-1] == 1'b0)
            return CORE_W'({s[SCALE_W-2:0], 1'b1});
        else
            return {s[SCALE_W-1:1], 2'b10};
    endfunction

    // Assemble the finite positive result
    function automatic logic [FP_W-1:0] pack_result(input logic [EXP_W-1:0] e,
                                                    input logic [EST_OUT_W-1:0] m);
        return {1'b0, e, m, {PAD_W{1'b0}}};
    endfunction

endpackage

// File: rtl/rsq_classify.sv
module rsq_classify
    import rsq_pkg::*;
(
    input  logic [FP_W-1:0] operand,
    input  logic            ftz_en,
    input  logic            dnan_en,
    output special_t        info
);
    logic             sgn;
    logic [EXP_W-1:0] ex;
    logic [MAN_W-1:0] man;
    logic             exp_max;
    logic             exp_min;

    assign sgn     = operand[FP_W-1];
    assign ex      = operand[FP_W-2:MAN_W];
    assign man     = operand[MAN_W-1:0];
    assign exp_max = (ex == {EXP_W{1'b1}});
    assign exp_min = (ex == '0);

    always_comb begin
        info = '0;
        if (exp_max && man != '0) begin
            info.special = 1'b1;
            info.invalid = ~man[MAN_W-1];
            info.value   = dnan_en ? DEFAULT_NAN
                                   : {operand[FP_W-1:MAN_W], 1'b1, man[MAN_W-2:0]};
        end else if (exp_min && (man == '0 || ftz_en)) begin
            info.special = 1'b1;
            info.divzero = 1'b1;
            info.value   = {sgn, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (sgn) begin
            info.special = 1'b1;
            info.invalid = 1'b1;
            info.value   = DEFAULT_NAN;
        end else if (exp_max) begin
            info.special = 1'b1;
            info.value   = '0;
        end
    end
endmodule

// File: rtl/rsq_search.sv
module rsq_search
    import rsq_pkg::*;
#(
    parameter int ITER_LIMIT = 512
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [SCALE_W-1:0]   scaled,
    output logic                 done,
    output logic [EST_OUT_W-1:0] est_lo
);
    localparam int CNT_W = $clog2(ITER_LIMIT + 1);
    localparam logic [PROD_W-1:0] BOUND = PROD_W'(1) << BOUND_LOG2;

    logic              run_q;
    logic [CORE_W-1:0] a_q;
    logic [B_W-1:0]    b_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [B_W-1:0]    bp1;
    logic [PROD_W-1:0] prod;
    logic              below;

    assign bp1   = b_q + B_W'(1);
    assign prod  = PROD_W'(a_q) * PROD_W'(bp1) * PROD_W'(bp1);
    assign below = (prod < BOUND);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q  <= 1'b0;
            a_q    <= '0;
            b_q    <= '0;
            cnt_q  <= '0;
            done   <= 1'b0;
            est_lo <= '0;
        end else begin
            done <= 1'b0;
            if (go) begin
                a_q   <= widen_core(scaled);
                b_q   <= B_W'(SEARCH_START);
                cnt_q <= '0;
                run_q <= 1'b1;
            end else if (run_q) begin
                if (below && cnt_q < CNT_W'(ITER_LIMIT)) begin
                    b_q   <= b_q + B_W'(1);
                    cnt_q <= cnt_q + CNT_W'(1);
                end else begin
                    run_q  <= 1'b0;
                    done   <= 1'b1;
                    est_lo <= bp1[EST_OUT_W:1];
                end
            end
        end
    end

    AST_CORE_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (a_q >= CORE_W'(257) && a_q <= CORE_W'(1022))); // R6
    AST_EST_RANGE: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (b_q >= B_W'(SEARCH_START) && b_q <= B_W'(2 * SEARCH_START - 2))); // R6
    AST_ITER_BOUND: assert property (@(posedge clk) disable iff (rst)
        run_q |-> (cnt_q <= CNT_W'(ITER_LIMIT))); // R12
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> !run_q); // R10
endmodule

// File: rtl/rsq_est.sv
module rsq_est
    import rsq_pkg::*;
#(
    parameter int ITER_LIMIT = 512
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [31:0]     operand,
    input  logic            ftz_en,
    input  logic            dnan_en,
    output logic            busy,
    output logic            done,
    output logic [31:0]     result,
    output logic            flag_invalid,
    output logic            flag_divzero
);
    ctl_state_t                state_q;
    logic signed [WEXP_W-1:0]  wexp_q;
    logic [MAN_W-1:0]          wfrac_q;
    logic [FP_W-1:0]           result_q;
    logic                      inv_q;
    logic                      dz_q;
    logic                      done_q;

    special_t                  cls;
    logic [SCALE_W-1:0]        scaled;
    logic                      launch;
    logic                      srch_done;
    logic [EST_OUT_W-1:0]      est_lo;
    logic [EXP_W-1:0]          exp_out;

    rsq_classify u_cls (
        .operand (operand),
        .ftz_en  (ftz_en),
        .dnan_en (dnan_en),
        .info    (cls)
    );

    // Parity of the working exponent picks the scaling form
    assign scaled = wexp_q[0] ? {2'b01, wfrac_q[MAN_W-1:MAN_W-7]}
                              : {1'b1,  wfrac_q[MAN_W-1:MAN_W-8]};
    assign launch = (state_q == ST_LAUNCH);
    assign exp_out = EXP_W'((EXP_OFFSET - int'(wexp_q)) >>> 1);

    rsq_search #(.ITER_LIMIT(ITER_LIMIT)) u_search (
        .clk    (clk),
        .rst    (rst),
        .go     (launch),
        .scaled (scaled),
        .done   (srch_done),
        .est_lo (est_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            wexp_q   <= '0;
            wfrac_q  <= '0;
            result_q <= '0;
            inv_q    <= 1'b0;
            dz_q     <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (cls.special) begin
                            result_q <= cls.value;
                            inv_q    <= cls.invalid;
                            dz_q     <= cls.divzero;
                            done_q   <= 1'b1;
                        end else begin
                            wexp_q  <= $signed({2'b00, operand[FP_W-2:MAN_W]});
                            wfrac_q <= operand[MAN_W-1:0];
                            state_q <= (operand[FP_W-2:MAN_W] == '0) ? ST_NORM : ST_LAUNCH;
                        end
                    end
                end
                ST_NORM: begin
                    wfrac_q <= {wfrac_q[MAN_W-2:0], 1'b0};
                    if (wfrac_q[MAN_W-1])
                        state_q <= ST_LAUNCH;
                    else
                        wexp_q <= wexp_q - WEXP_W'(1);
                end
                ST_LAUNCH: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (srch_done) begin
                        result_q <= pack_result(exp_out, est_lo);
                        inv_q    <= 1'b0;
                        dz_q     <= 1'b0;
                        done_q   <= 1'b1;
                        state_q  <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy         = (state_q != ST_IDLE);
    assign done         = done_q;
    assign result       = result_q;
    assign flag_invalid = inv_q;
    assign flag_divzero = dz_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q); // R10
    AST_HOLD_WORK: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && start) |=> ($stable(wexp_q) && $stable(wfrac_q))); // R11
    AST_NORM_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_NORM && !wfrac_q[MAN_W-1]) |=> (wexp_q == $past(wexp_q) - 1)); // R8
    AST_DZ_INF: assert property (@(posedge clk) disable iff (rst)
        (done_q && dz_q) |-> (result_q[FP_W-2:0] == {{EXP_W{1'b1}}, {MAN_W{1'b0}}} && !inv_q)); // R1
    AST_INV_NAN: assert property (@(posedge clk) disable iff (rst)
        (done_q && inv_q) |-> (result_q[FP_W-2:MAN_W-1] == {(EXP_W+1){1'b1}})); // R2
    AST_SEARCH_POSITIVE: assert property (@(posedge clk) disable iff (rst)
        (srch_done && state_q == ST_WAIT) |=> (done_q && !result_q[FP_W-1])); // R6
endmodule

// File: tb/sim_rsq_est.sv
module sim_rsq_est;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] operand = '0;
    logic        ftz_en = 1'b0;
    logic        dnan_en = 1'b0;
    logic        busy;
    logic        done;
    logic [31:0] result;
    logic        flag_invalid;
    logic        flag_divzero;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    rsq_est u0 (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .operand      (operand),
        .ftz_en       (ftz_en),
        .dnan_en      (dnan_en),
        .busy         (busy),
        .done         (done),
        .result       (result),
        .flag_invalid (flag_invalid),
        .flag_divzero (flag_divzero)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 190000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Independent model of the core search from R6
    function automatic logic [7:0] model_est(input int s);
        longint a, b;
        a = (s < 256) ? (2 * s + 1) : (((s / 2) * 2 + 1) * 2);
        b = 512;
        while (a * (b + 1) * (b + 1) < (64'd1 << 28)) b++;
        return 8'(((b + 1) / 2) % 256);
    endfunction

    // Issue one operation and wait for done; got = {inv, dz, result}
    task automatic run_op(input logic [31:0] op, input logic f, input logic d,
                          output logic [33:0] got, output int cyc,
                          output logic busy1, output logic done1);
        @(negedge clk);
        operand = op; ftz_en = f; dnan_en = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        busy1 = busy;
        done1 = done;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        if (!done) begin
            n_bad++;
            $display("FAIL op watchdog: actual=no done expected=done for %h", op);
        end
        got = {flag_invalid, flag_divzero, result};
    endtask

    localparam int NV = 20;
    localparam logic [31:0] V_OP [NV] = '{
        32'h0000_0000, 32'h8000_0000, 32'hBF80_0000, 32'hFF80_0000, 32'h7F80_0000,
        32'h7F80_0001, 32'h7FC1_2345, 32'h7FC1_2345, 32'h7F80_0001, 32'hFF80_0001,
        32'h0000_0001, 32'h8000_0001, 32'h8000_0001, 32'h3F80_0000, 32'h4000_0000,
        32'h4080_0000, 32'h7F7F_FFFF, 32'h0000_0001, 32'h0040_0000, 32'h3F80_0000
    };
    // {ftz_en, dnan_en}
    localparam logic [1:0] V_MODE [NV] = '{
        2'b00, 2'b00, 2'b00, 2'b00, 2'b00,
        2'b00, 2'b00, 2'b01, 2'b01, 2'b00,
        2'b10, 2'b10, 2'b00, 2'b00, 2'b00,
        2'b00, 2'b00, 2'b00, 2'b00, 2'b10
    };
    // {invalid, divzero, result}
    localparam logic [33:0] V_EXP [NV] = '{
        {2'b01, 32'h7F80_0000},  // R1 +0
        {2'b01, 32'hFF80_0000},  // R1 -0
        {2'b10, 32'h7FC0_0000},  // R2 -1.0
        {2'b10, 32'h7FC0_0000},  // R2 -inf
        {2'b00, 32'h0000_0000},  // R3 +inf
        {2'b10, 32'h7FC0_0001},  // R4 signalling quietened
        {2'b00, 32'h7FC1_2345},  // R4 quiet passes
        {2'b00, 32'h7FC0_0000},  // R4 default NaN mode, quiet
        {2'b10, 32'h7FC0_0000},  // R4 default NaN mode, signalling
        {2'b10, 32'hFFC0_0001},  // R4 negative signalling
        {2'b01, 32'h7F80_0000},  // R5 flushed subnormal
        {2'b01, 32'hFF80_0000},  // R5 flushed negative subnormal
        {2'b10, 32'h7FC0_0000},  // R2 negative subnormal kept
        {2'b00, 32'h3F7F_8000},  // R7 odd exponent
        {2'b00, 32'h3F34_8000},  // R7 even exponent
        {2'b00, 32'h3EFF_8000},  // R9 exponent of 4.0
        {2'b00, 32'h1F80_0000},  // R9 largest normal
        {2'b00, 32'h64B4_8000},  // R8 22 shifts
        {2'b00, 32'h5F34_8000},  // R8 no shift
        {2'b00, 32'h3F7F_8000}   // R5 normal unaffected by flush
    };
    localparam int V_REQ [NV] = '{1, 1, 2, 2, 3, 4, 4, 4, 4, 4, 5, 5, 2, 7, 7, 9, 9, 8, 8, 5};

    initial begin
        logic [33:0] got;
        int          cyc;
        logic        b1, d1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk("R10 reset", {29'b0, busy, done, flag_invalid, flag_divzero, result},
            64'h0);

        for (int i = 0; i < NV; i++) begin
            run_op(V_OP[i], V_MODE[i][1], V_MODE[i][0], got, cyc, b1, d1);
            chk($sformatf("vec %0d R%0d", i, V_REQ[i]), 64'(got), 64'(V_EXP[i]));
        end

        // R10 special: done the cycle after start with busy low, then one-cycle pulse
        run_op(32'h0000_0000, 1'b0, 1'b0, got, cyc, b1, d1);
        chk("R10 special timing", {62'b0, b1, d1}, 64'b01);
        @(negedge clk);
        chk("R10 done pulse special", 64'(done), 64'h0);

        // R10 and R12 on the slowest operand
        run_op(32'h3F80_0000, 1'b0, 1'b0, got, cyc, b1, d1);
        chk("R10 busy after start", {62'b0, b1, d1}, 64'b10);
        chk("R12 latency bound", 64'((cyc >= 505 && cyc <= 520) ? 1 : 0), 64'h1);
        @(negedge clk);
        chk("R10 done pulse normal", {62'b0, busy, done}, 64'b00);

        // R11: start during busy is ignored
        @(negedge clk);
        operand = 32'h3F80_0000; ftz_en = 1'b0; dnan_en = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        operand = 32'h0000_0000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        operand = '0;
        cyc = 0;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R11 start ignored while busy", {30'b0, flag_invalid, flag_divzero, result},
            {30'b0, 2'b00, 32'h3F7F_8000});
        chk("R11 long run kept", 64'((cyc > 400) ? 1 : 0), 64'h1);

        // R6 sweep of every scaled value; odd exponent 127 then even exponent 128
        for (int s = 128; s < 512; s++) begin
            logic [31:0] op;
            if (s < 256) op = {1'b0, 8'd127, 7'(s - 128), 16'h0};
            else         op = {1'b0, 8'd128, 8'(s - 256), 15'h0};
            run_op(op, 1'b0, 1'b0, got, cyc, b1, d1);
            chk($sformatf("R6 sweep scaled=%0d", s), 64'(got),
                64'({2'b00, 1'b0, 8'd126, model_est(s), 15'h0}));
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule